// File: doc/BRIEF.md
# Multi-Waveform Direct Digital Synthesis Oscillator

This block is a clock-enabled direct digital synthesis oscillator for audio. It runs in a single clock domain. Two strobes from outside pace it: a fast phase strobe (nominally 480 kHz) and a slow sample strobe (nominally 48 kHz). On each phase strobe a phase accumulator adds the frequency word, and a pseudo-random noise register steps once.

Five waveforms are derived from this state: saw, square, variable-width pulse, triangle and noise. A three-bit selector picks one of them. On each sample strobe the selected value is latched into the signed 16-bit audio output. With the nominal strobe rates this keeps every tenth oscillator value, with no interpolation or filtering.

Top module: `dds_wave_osc`

## Requirements
- R1: On a clock edge with `phase_tick` high, the internal phase becomes (phase + `freq_word`) mod 2^24. Without `phase_tick` the phase holds. Reset sets the phase to 0.
- R2: `sample_out` changes only on an edge with `sample_tick` high. It then takes the selected waveform computed from the phase and noise state held before that edge, so a phase step on the same edge is not yet visible.
- R3: With `wave_sel` = 0 (saw), the output is phase bits [23:8] with bit 15 inverted. Phase 0 gives 0x8000 and phase 0xFFFFFF gives 0x7FFF.
- R4: With `wave_sel` = 1 (square), the output is 0x7FFF when phase bit 23 is 1 and 0x8000 when it is 0.
- R5: With `wave_sel` = 2 (pulse), the threshold is `pulse_width` shifted left by 16. The output is 0x7FFF while phase < threshold and 0x8000 otherwise. A width of 0 always gives 0x8000.
- R6: With `wave_sel` = 3 (triangle), the lower 23 phase bits are inverted when phase bit 23 is 1. Bits [22:7] of that result are the output.
- R7: With `wave_sel` = 4 (noise), the output is bits [22:7] of a 23-bit shift register. On each `phase_tick` the register shifts left and takes bit 22 XOR bit 17 into bit 0. Reset loads the seed 0x2B3C5D, and the register never becomes zero.
- R8: With `wave_sel` = 5, 6 or 7, the captured output is 0x0000.
- R9: Reset sets `sample_out` to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| phase_tick | input | 1 | Enable that advances phase and noise |
| sample_tick | input | 1 | Enable that latches the output sample |
| freq_word | input | 24 | Phase increment per phase tick |
| wave_sel | input | 3 | Waveform selector |
| pulse_width | input | 8 | Pulse waveform duty threshold |
| sample_out | output | 16 | Signed audio sample |

## Verification
Directed runs use frequency words of 0, 1 and all-ones, which separate holding, slow stepping and wrap-around. Pulse widths of 0, 0x80 and 0xFF probe the comparator edges. A run with the nominal ten-to-one strobe ratio shows decimation and the ordering of strobes that land on the same edge. Random runs vary the frequency word, the selector and the strobe density together. Each waveform is then compared against a bench model of the phase and noise registers. Captures with no phase step between them are included, as they separate the noise source's stepping rule from free-running behaviour.

// File: rtl/dds_wave_osc.sv
module dds_wave_osc #(
  parameter int PHASE_W = 24,
  parameter int SAMPLE_W = 16,
  parameter int WIDTH_W = 8,
  parameter logic [22:0] NOISE_SEED = 23'h2B3C5D
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                phase_tick,
  input  logic                sample_tick,
  input  logic [PHASE_W-1:0]  freq_word,
  input  logic [2:0]          wave_sel,
  input  logic [WIDTH_W-1:0]  pulse_width,
  output logic [SAMPLE_W-1:0] sample_out
);
  localparam int NOISE_W = 23;
  localparam logic [SAMPLE_W-1:0] POS_FULL = {1'b0, {(SAMPLE_W-1){1'b1}}};
  localparam logic [SAMPLE_W-1:0] NEG_FULL = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic [PHASE_W-1:0]  phase;
  logic [NOISE_W-1:0]  noise;
  logic [PHASE_W-1:0]  pulse_thr;
  logic [PHASE_W-2:0]  refl;
  logic [SAMPLE_W-1:0] saw_v, sq_v, pulse_v, tri_v, noise_v;
  logic [SAMPLE_W-1:0] osc_v;

  assign saw_v     = {~phase[PHASE_W-1], phase[PHASE_W-2 -: SAMPLE_W-1]};
  assign sq_v      = phase[PHASE_W-1] ? POS_FULL : NEG_FULL;
  assign pulse_thr = {pulse_width, {(PHASE_W-WIDTH_W){1'b0}}};
  assign pulse_v   = (phase < pulse_thr) ? POS_FULL : NEG_FULL;
  assign refl      = phase[PHASE_W-1] ? ~phase[PHASE_W-2:0] : phase[PHASE_W-2:0];
  assign tri_v     = refl[PHASE_W-2 -: SAMPLE_W];
  assign noise_v   = noise[NOISE_W-1 -: SAMPLE_W];

  always_comb begin
    case (wave_sel)
      3'd0:    osc_v = saw_v;
      3'd1:    osc_v = sq_v;
      3'd2:    osc_v = pulse_v;
      3'd3:    osc_v = tri_v;
      3'd4:    osc_v = noise_v;
      default: osc_v = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      noise <= NOISE_SEED;
    end else if (phase_tick) begin
      phase <= phase + freq_word;
      noise <= {noise[NOISE_W-2:0], noise[22] ^ noise[17]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sample_out <= '0;
    else if (sample_tick) sample_out <= osc_v;
  end

  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_tick |=> $stable(sample_out));

  // R4
  square_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && wave_sel == 3'd1) |=> (sample_out == POS_FULL || sample_out == NEG_FULL));

  // R5
  pulse_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && wave_sel == 3'd2 && pulse_width == '0) |=> sample_out == NEG_FULL);

  // R8
  unused_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && wave_sel >= 3'd5) |=> sample_out == '0);

  // R7
  noise_alive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    noise != '0);

  // R1
  phase_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_tick |=> $stable(phase) && $stable(noise));
endmodule

// File: tb/dds_wave_osc_test.sv
module dds_wave_osc_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        phase_tick = 1'b0;
  logic        sample_tick = 1'b0;
  logic [23:0] freq_word = '0;
  logic [2:0]  wave_sel = '0;
  logic [7:0]  pulse_width = '0;
  logic [15:0] sample_out;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [23:0] m_phase;
  logic [22:0] m_noise;
  logic [15:0] m_out;

  dds_wave_osc uut (
    .clk(clk), .rst_n(rst_n), .phase_tick(phase_tick), .sample_tick(sample_tick),
    .freq_word(freq_word), .wave_sel(wave_sel), .pulse_width(pulse_width),
    .sample_out(sample_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] model_wave(input logic [23:0] ph, input logic [22:0] nz,
                                             input logic [2:0] sel, input logic [7:0] pw);
    logic [22:0] r;
    case (sel)
      3'd0: return ph[23:8] ^ 16'h8000;
      3'd1: return ph[23] ? 16'h7FFF : 16'h8000;
      3'd2: return (ph < {pw, 16'h0000}) ? 16'h7FFF : 16'h8000;
      3'd3: begin
        r = ph[23] ? ~ph[22:0] : ph[22:0];
        return r[22:7];
      end
      3'd4: return nz[22:7];
      default: return 16'h0000;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] sel, input logic st);
    if (!st) return "R2";
    case (sel)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: sample_out=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic pt, input logic st, input logic [23:0] fw,
                      input logic [2:0] ws, input logic [7:0] pw);
    phase_tick = pt; sample_tick = st; freq_word = fw; wave_sel = ws; pulse_width = pw;
    if (st) m_out = model_wave(m_phase, m_noise, ws, pw);
    if (pt) begin
      m_phase = m_phase + fw;
      m_noise = {m_noise[21:0], m_noise[22] ^ m_noise[17]};
    end
    @(posedge clk);
    @(negedge clk);
    check(req_of(ws, st), sample_out, m_out);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_phase = '0; m_noise = 23'h2B3C5D; m_out = '0;
    repeat (3) @(negedge clk);
    check("R9", sample_out, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", sample_out, 16'h0000);

    // R3 / R7 reset state visible through the output
    step(0, 1, 24'h0, 3'd0, 8'h00);
    step(0, 1, 24'h0, 3'd4, 8'h00);
    step(0, 1, 24'h0, 3'd1, 8'h00);
    // R1 zero increment holds, wrap with all-ones
    step(1, 1, 24'h0, 3'd0, 8'h00);
    step(1, 1, 24'hFFFFFF, 3'd0, 8'h00);
    step(0, 1, 24'h0, 3'd0, 8'h00);
    step(0, 1, 24'h0, 3'd3, 8'h00);
    step(1, 0, 24'h000001, 3'd0, 8'h00);
    step(0, 1, 24'h0, 3'd0, 8'h00);
    // R5 width corners
    step(0, 1, 24'h0, 3'd2, 8'h00);
    step(0, 1, 24'h0, 3'd2, 8'hFF);
    step(1, 0, 24'h800000, 3'd2, 8'h80);
    step(0, 1, 24'h0, 3'd2, 8'h80);
    step(0, 1, 24'h0, 3'd2, 8'hFF);
    // R8 unused selector codes
    for (int s = 5; s < 8; s++) step(0, 1, 24'h0, 3'(s), 8'h00);
    // R7 noise holds with no phase tick
    step(0, 1, 24'h0, 3'd4, 8'h00);
    step(0, 1, 24'h0, 3'd4, 8'h00);

    // R2 ten-to-one decimation, sample strobe on a phase edge
    for (int i = 0; i < 400; i++)
      step(1, (i % 10) == 9, 24'h01234F, 3'(i / 80), 8'h40);

    // random mix
    for (int i = 0; i < 6000; i++)
      step(($urandom % 3) != 0, ($urandom % 4) == 0, $urandom,
           3'($urandom % 8), 8'($urandom));

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule